// File: doc/BRIEF.md
# Pipelined Integer Multiply Unit

This block is the multiply stage of a 64-bit processor execution pipeline. Each cycle it can take one operation: two 65-bit operands, an operation code, a destination register number and a flag asking for a condition update. Upstream decode has already widened the operands by one bit. Unsigned 64-bit forms arrive zero-extended. Signed forms arrive sign-extended. Word forms are extended from bit 31, and 16-bit immediates from bit 15. Because of this, one signed 65x65 datapath serves every signed and unsigned variant.

The unit has a fixed latency and accepts a new operation every cycle. The full signed product is formed, and one slice of it is returned according to the operation code. The result comes out with a register write enable and the destination number. When the caller asks for it, a 32-bit condition word is also produced, whose top nibble classifies the result as negative, positive or zero.

Top module: `mulp_unit`

## Requirements
- R1: With latency parameter LAT (default 4, minimum 3), an input sampled with `in_valid` high on a rising edge gives `out_valid` high in exactly the cycle after the LAT-th rising edge, counting the sampling edge as the first. `out_valid` is high for one cycle per accepted input.
- R2: In a cycle with no result due, `out_valid`, `out_wr_en` and `out_cr_en` are all low.
- R3: Operation code 0 (low) returns bits 63:0 of the signed product of the two 65-bit operands. Code 3 behaves exactly like code 0.
- R4: Operation code 1 (high) returns bits 127:64 of the signed product.
- R5: Operation code 2 (high word) places bits 63:32 of the product in both `out_data[31:0]` and `out_data[63:32]`.
- R6: `out_dest` equals the destination number given with the input, and `out_wr_en` is high together with `out_valid`.
- R7: With the record flag clear, `out_cr_en` is low and `out_cr_word` is zero.
- R8: With the record flag set, `out_cr_en` is high. `out_cr_word[31:28]` is 1000 for a negative result (bit 63 set), 0100 for a positive non-zero result and 0010 for zero. Bits 28 and 27:0 are zero. Example: 0x1000 times 0x1111, low, recorded gives data 0x0000000001111000 and word 0x40000000.
- R9: Operations issued on consecutive cycles, with any op code mix, each return their own result, in issue order, with no loss or duplication.
- R10: While and right after reset (active-low `rst_n`), `out_valid`, `out_wr_en` and `out_cr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Result slice: 0 low, 1 high, 2 high word, 3 as low |
| in_dest | input | 5 | Destination register number |
| in_rec | input | 1 | Request a condition word |
| in_a | input | 65 | First operand, pre-extended, signed |
| in_b | input | 65 | Second operand, pre-extended, signed |
| out_valid | output | 1 | Result present |
| out_wr_en | output | 1 | Register write enable |
| out_dest | output | 5 | Destination register number |
| out_data | output | 64 | Selected product slice |
| out_cr_en | output | 1 | Condition write enable |
| out_cr_word | output | 32 | Condition word, field in bits 31:28 |

## Verification
The cases hardest to reach from the ports are a zero or all-ones high slice under a condition request, with the classification landing on a result several stages in flight behind different op codes. Random wide operands almost never give a zero high half. The stimulus therefore mixes small-magnitude and sign-extended word and immediate operands, which force zero and minus-one upper halves, into streams issued back to back. Random single-cycle bubbles are placed between them, so that each result must be matched to its own issue cycle.

// File: rtl/mulp_pkg.sv
package mulp_pkg;

    localparam int REGW      = 5;
    localparam int CRW       = 32;
    localparam int CR_FIELDW = 4;

    localparam logic [CR_FIELDW-1:0] CR_NEG  = 4'b1000;
    localparam logic [CR_FIELDW-1:0] CR_POS  = 4'b0100;
    localparam logic [CR_FIELDW-1:0] CR_ZERO = 4'b0010;

    typedef enum logic [1:0] {
        MOP_LO  = 2'd0,
        MOP_HI  = 2'd1,
        MOP_HW  = 2'd2,
        MOP_ALT = 2'd3
    } mop_e;

    // control token that travels beside the data
    typedef struct packed {
        logic            vld;
        mop_e            op;
        logic [REGW-1:0] dest;
        logic            rec;
    } mtag_t;

endpackage

// File: rtl/mulp_prod_stage.sv
module mulp_prod_stage
    import mulp_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mtag_t             tag_i,
    input  logic [XLEN:0]     a_i,
    input  logic [XLEN:0]     b_i,
    output mtag_t             tag_o,
    output logic [2*XLEN-1:0] prod_o
);
    localparam int OPW = XLEN + 1;
    localparam int PW  = 2 * OPW;
    localparam int RW  = 2 * XLEN;

    typedef struct packed {
        mtag_t          s1_tag;
        logic [OPW-1:0] s1_a;
        logic [OPW-1:0] s1_b;
        mtag_t          s2_tag;
        logic [RW-1:0]  s2_p;
    } st_t;

    st_t st_d, st_q;
    logic signed [PW-1:0] a_ext, b_ext;

    always_comb begin
        st_d = st_q;
        // stage 1: capture operands only for real operations
        st_d.s1_tag = tag_i;
        if (tag_i.vld) begin
            st_d.s1_a = a_i;
            st_d.s1_b = b_i;
        end
        // stage 2: full signed product, top two bits never selected
        a_ext = PW'($signed(st_q.s1_a));
        b_ext = PW'($signed(st_q.s1_b));
        st_d.s2_tag = st_q.s1_tag;
        if (st_q.s1_tag.vld) begin
            st_d.s2_p = RW'(a_ext * b_ext);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tag_o  = st_q.s2_tag;
    assign prod_o = st_q.s2_p;

endmodule

// File: rtl/mulp_delay.sv
module mulp_delay #(
    parameter int W = 8,
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] d_o
);
    generate
        if (N == 0) begin : g_wire
            assign d_o = d_i;
        end else begin : g_regs
            logic [W-1:0] pipe_d [N];
            logic [W-1:0] pipe_q [N];

            always_comb begin
                pipe_d[0] = d_i;
                for (int i = 1; i < N; i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < N; i++) begin
                        pipe_q[i] <= '0;
                    end
                end else begin
                    for (int i = 0; i < N; i++) begin
                        pipe_q[i] <= pipe_d[i];
                    end
                end
            end

            assign d_o = pipe_q[N-1];
        end
    endgenerate

endmodule

// File: rtl/mulp_result_fmt.sv
module mulp_result_fmt
    import mulp_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mtag_t             tag_i,
    input  logic [2*XLEN-1:0] prod_i,
    output logic              valid_o,
    output logic              wr_en_o,
    output logic [REGW-1:0]   dest_o,
    output logic [XLEN-1:0]   data_o,
    output logic              cr_en_o,
    output logic [CRW-1:0]    cr_word_o
);
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        logic            vld;
        logic            wr;
        logic [REGW-1:0] dest;
        logic [XLEN-1:0] data;
        logic            cr_en;
        logic [CRW-1:0]  cr;
    } out_t;

    out_t out_d, out_q;
    logic [XLEN-1:0]      sel;
    logic [CR_FIELDW-1:0] fld;

    always_comb begin
        unique case (tag_i.op)
            MOP_HI:  sel = prod_i[2*XLEN-1:XLEN];
            MOP_HW:  sel = {2{prod_i[XLEN-1:HALF]}};
            default: sel = prod_i[XLEN-1:0];
        endcase

        if (sel == '0) begin
            fld = CR_ZERO;
        end else if (sel[XLEN-1]) begin
            fld = CR_NEG;
        end else begin
            fld = CR_POS;
        end

        out_d       = out_q;
        out_d.vld   = tag_i.vld;
        out_d.wr    = tag_i.vld;
        out_d.cr_en = tag_i.vld & tag_i.rec;
        out_d.cr    = (tag_i.vld & tag_i.rec) ? {fld, {(CRW-CR_FIELDW){1'b0}}} : '0;
        if (tag_i.vld) begin
            out_d.dest = tag_i.dest;
            out_d.data = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_o   = out_q.vld;
    assign wr_en_o   = out_q.wr;
    assign dest_o    = out_q.dest;
    assign data_o    = out_q.data;
    assign cr_en_o   = out_q.cr_en;
    assign cr_word_o = out_q.cr;

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!wr_en_o && !cr_en_o));

    a_r7_no_cr_without_result: assert property (@(posedge clk) disable iff (!rst_n)
        !cr_en_o |-> (cr_word_o == '0));

    a_r8_field_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        cr_en_o |-> ($onehot(cr_word_o[CRW-1:CRW-CR_FIELDW]) &&
                     cr_word_o[CRW-CR_FIELDW:0] == '0));

    a_r8_negative_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_en_o && data_o[XLEN-1]) |-> cr_word_o[CRW-1]);

endmodule

// File: rtl/mulp_unit.sv
module mulp_unit
    import mulp_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int LAT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [REGW-1:0]   in_dest,
    input  logic              in_rec,
    input  logic [XLEN:0]     in_a,
    input  logic [XLEN:0]     in_b,
    output logic              out_valid,
    output logic              out_wr_en,
    output logic [REGW-1:0]   out_dest,
    output logic [XLEN-1:0]   out_data,
    output logic              out_cr_en,
    output logic [CRW-1:0]    out_cr_word
);
    // two product stages and one output stage; the rest is delay
    localparam int NDLY = LAT - 3;
    localparam int RW   = 2 * XLEN;
    localparam int TW   = $bits(mtag_t);

    generate
        if (LAT < 3) begin : g_bad_lat
            $error("mulp_unit: LAT must be at least 3");
        end
    endgenerate

    mtag_t           tag_in, tag_p, tag_f;
    logic [RW-1:0]   prod_p, prod_f;
    logic [TW+RW-1:0] dly_in, dly_out;

    assign tag_in = '{vld: in_valid, op: mop_e'(in_op), dest: in_dest, rec: in_rec};

    mulp_prod_stage #(.XLEN(XLEN)) u_prod (
        .clk    (clk),
        .rst_n  (rst_n),
        .tag_i  (tag_in),
        .a_i    (in_a),
        .b_i    (in_b),
        .tag_o  (tag_p),
        .prod_o (prod_p)
    );

    assign dly_in = {tag_p, prod_p};

    mulp_delay #(.W(TW + RW), .N(NDLY)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (dly_in),
        .d_o   (dly_out)
    );

    assign tag_f  = mtag_t'(dly_out[TW+RW-1:RW]);
    assign prod_f = dly_out[RW-1:0];

    mulp_result_fmt #(.XLEN(XLEN)) u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tag_i     (tag_f),
        .prod_i    (prod_f),
        .valid_o   (out_valid),
        .wr_en_o   (out_wr_en),
        .dest_o    (out_dest),
        .data_o    (out_data),
        .cr_en_o   (out_cr_en),
        .cr_word_o (out_cr_word)
    );

    // input-valid history used to check the latency at the ports
    logic [LAT-1:0] vld_hist_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_hist_q <= '0;
        end else begin
            vld_hist_q <= {vld_hist_q[LAT-2:0], in_valid};
        end
    end

    a_r1_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_hist_q[LAT-1]);

    a_r6_wren_tracks_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en == vld_hist_q[LAT-1]);

endmodule

// File: tb/mulp_unit_tb_top.sv
module mulp_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam int LAT  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [1:0]      in_op = 2'd0;
    logic [4:0]      in_dest = 5'd0;
    logic            in_rec = 1'b0;
    logic [XLEN:0]   in_a = '0;
    logic [XLEN:0]   in_b = '0;
    logic            out_valid, out_wr_en, out_cr_en;
    logic [4:0]      out_dest;
    logic [XLEN-1:0] out_data;
    logic [31:0]     out_cr_word;

    mulp_unit #(.XLEN(XLEN), .LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dest(in_dest), .in_rec(in_rec), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_wr_en(out_wr_en), .out_dest(out_dest),
        .out_data(out_data), .out_cr_en(out_cr_en), .out_cr_word(out_cr_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [63:0] data;
        logic [4:0]  dest;
        logic        rec;
        string       tag;
    } exp_t;

    exp_t expq[$];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // reference: shift-and-add on magnitudes, then sign fix
    function automatic logic [129:0] ref_mul(input logic [64:0] a, input logic [64:0] b);
        logic [64:0]  ma, mb;
        logic [129:0] acc;
        logic         neg;
        ma  = a[64] ? (~a + 65'd1) : a;
        mb  = b[64] ? (~b + 65'd1) : b;
        neg = a[64] ^ b[64];
        acc = '0;
        for (int i = 0; i < 65; i++) begin
            if (mb[i]) acc = acc + ({65'd0, ma} << i);
        end
        return neg ? (~acc + 130'd1) : acc;
    endfunction

    function automatic logic [63:0] ref_sel(input logic [1:0] op, input logic [129:0] p);
        case (op)
            2'd1:    return p[127:64];
            2'd2:    return {p[63:32], p[63:32]};
            default: return p[63:0];
        endcase
    endfunction

    function automatic logic [31:0] ref_cr(input logic [63:0] d);
        if (d == 64'd0) return 32'h2000_0000;
        if (d[63])      return 32'h8000_0000;
        return 32'h4000_0000;
    endfunction

    function automatic logic [64:0] sx(input logic [63:0] v);
        return {v[63], v};
    endfunction

    // kinds: 0 unsigned64, 1 signed64, 2 signed word, 3 unsigned word, 4 imm16
    function automatic logic [64:0] gen_opnd(input int kind);
        logic [63:0] r;
        r = {$urandom, $urandom};
        case (kind)
            0:       return {1'b0, r};
            1:       return {r[63], r};
            2:       return {{33{r[31]}}, r[31:0]};
            3:       return {33'd0, r[31:0]};
            default: return {{49{r[15]}}, r[15:0]};
        endcase
    endfunction

    task automatic issue(input logic [1:0] op, input logic [64:0] a, input logic [64:0] b,
                         input logic [4:0] d, input logic rec, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_a     = a;
        in_b     = b;
        in_dest  = d;
        in_rec   = rec;
        e.due  = cyc + LAT;
        e.data = ref_sel(op, ref_mul(a, b));
        e.dest = d;
        e.rec  = rec;
        e.tag  = tag;
        expq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_a     = {$urandom, $urandom, 1'b1};
            in_rec   = 1'b1;
        end
    endtask

    // output monitor: every cycle either a result is due or the port is quiet
    always @(negedge clk) begin : mon
        exp_t e;
        if (mon_on) begin
            if (expq.size() > 0 && expq[0].due == cyc) begin
                e = expq.pop_front();
                chk("R1 result valid on time", 64'(out_valid), 64'd1);
                chk({e.tag, " data"}, out_data, e.data);
                chk("R6 dest", 64'(out_dest), 64'(e.dest));
                chk("R6 write enable", 64'(out_wr_en), 64'd1);
                if (e.rec) begin
                    chk("R8 cr enable", 64'(out_cr_en), 64'd1);
                    chk("R8 cr word", 64'(out_cr_word), 64'(ref_cr(e.data)));
                end else begin
                    chk("R7 cr enable", 64'(out_cr_en), 64'd0);
                    chk("R7 cr word", 64'(out_cr_word), 64'd0);
                end
            end else begin
                chk("R2 idle valid", 64'(out_valid), 64'd0);
                chk("R2 idle wr_en", 64'(out_wr_en), 64'd0);
                chk("R2 idle cr_en", 64'(out_cr_en), 64'd0);
            end
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset valid", 64'(out_valid), 64'd0);
        chk("R10 reset wr_en", 64'(out_wr_en), 64'd0);
        chk("R10 reset cr_en", 64'(out_cr_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset valid", 64'(out_valid), 64'd0);
        mon_on = 1'b1;
    endtask

    task automatic t_example();
        // R3 and R8 worked example, checked against literals as well
        issue(2'd0, 65'h1000, 65'h1111, 5'd17, 1'b0, "R3 example");
        idle(LAT - 1);
        @(negedge clk);
        chk("R3 example literal", out_data, 64'h0000_0000_0111_1000);
        idle(2);
        issue(2'd0, 65'h1000, 65'h1111, 5'd17, 1'b1, "R8 example");
        idle(LAT - 1);
        @(negedge clk);
        chk("R8 example literal", 64'(out_cr_word), 64'h4000_0000);
        idle(2);
    endtask

    task automatic t_cond();
        issue(2'd0, sx(-64'sd5), 65'd3, 5'd1, 1'b1, "R8 negative low");
        issue(2'd0, 65'd0, sx(-64'sd9), 5'd2, 1'b1, "R8 zero low");
        issue(2'd1, 65'd12345, 65'd777, 5'd3, 1'b1, "R4 zero high");
        issue(2'd1, sx(-64'sd1), 65'd1, 5'd4, 1'b1, "R4 all-ones high");
        issue(2'd1, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF}, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
              5'd5, 1'b1, "R4 unsigned max");
        issue(2'd0, sx(-64'sd5), 65'd3, 5'd6, 1'b0, "R7 negative no record");
        idle(LAT + 1);
    endtask

    task automatic t_word();
        issue(2'd2, {{33{1'b1}}, 32'h8000_0000}, 65'd2, 5'd7, 1'b1, "R5 word negative");
        issue(2'd2, {33'd0, 32'hFFFF_FFFF}, {33'd0, 32'hFFFF_FFFF}, 5'd8, 1'b1, "R5 word unsigned");
        issue(2'd2, 65'd3, 65'd4, 5'd9, 1'b1, "R5 word zero high");
        idle(LAT + 1);
    endtask

    task automatic t_alt_code();
        for (int i = 0; i < 100; i++) begin
            issue(2'd3, gen_opnd(1), gen_opnd(1), 5'($urandom), 1'($urandom), "R3 code3");
        end
        idle(LAT + 1);
    endtask

    task automatic t_stream(input logic [1:0] op, input int ka, input int kb, input string tag);
        int kind;
        logic [64:0] a, b;
        for (int i = 0; i < 1000; i++) begin
            kind = ($urandom % 2 == 0) ? ka : kb;
            a = gen_opnd(kind == 4 ? 1 : kind);
            b = gen_opnd(kind);
            if ($urandom % 16 == 0) a = 65'($urandom % 8);
            issue(op, a, b, 5'($urandom), 1'($urandom), tag);
            if ($urandom % 10 == 0) idle(1);
        end
        idle(LAT + 1);
    endtask

    task automatic t_mixed();
        logic [1:0] op;
        for (int i = 0; i < 300; i++) begin
            op = 2'($urandom);
            issue(op, gen_opnd(2), gen_opnd(int'($urandom % 5)), 5'($urandom), 1'b1, "R9 mixed stream");
            if ($urandom % 4 == 0) idle(int'($urandom % 3));
        end
        idle(LAT + 2);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        t_reset();
        t_example();
        t_cond();
        t_word();
        t_stream(2'd0, 0, 1, "R3 low random");
        t_stream(2'd0, 2, 4, "R3 low word/imm random");
        t_stream(2'd1, 0, 1, "R4 high random");
        t_stream(2'd2, 2, 3, "R5 word random");
        t_alt_code();
        t_mixed();
        chk("R9 all results delivered", 64'(expq.size()), 64'd0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule